// File: doc/BRIEF.md
# Prescaled Single-Channel Pulse-Width Modulator

This block drives one pulse-width modulated output. It is programmed through two 32-bit words on a plain register bus with an address, a write strobe, write data and combinational read data. A control word sets the tick source, the output sense and the run conditions. A period word sets how many prescaled ticks make up one period and how many of those ticks are active. Software works out the tick counts; the block only counts them.

The tick source is a prescaler selected by a 4-bit code. The code set is sparse. Ten codes divide the input clock by fixed amounts that are not powers of two. One code passes the clock straight through. The remaining codes stop the ticks.

A new period word does not disturb the period in progress. It waits in a shadow register and is loaded at the next period boundary. A ready flag in the control word reads 1 while a value is waiting. A channel that is not running treats every clock as a boundary.

Top module: `pwm_chan`

## Requirements
- R1: The control word sits at bus address 0x0 and the period word at address 0x4. Control bits [3:0] hold the prescaler code, bit 4 the enable, bit 5 the active level and bit 6 the clock gate. A read of address 0x0 returns those seven stored bits and the live ready flag in bit 28, with every other bit zero. A read of address 0x4 returns the last period word written. Any other address reads as zero.
- R2: Prescaler codes 0x0, 0x1, 0x2, 0x3 and 0x4 give one tick every 120, 180, 240, 360 and 480 clocks. Codes 0x8, 0x9, 0xA, 0xB and 0xC give one tick every 12000, 24000, 36000, 48000 and 72000 clocks. Code 0xF gives a tick on every clock.
- R3: Period word bits [31:16] hold the period length minus one, counted in ticks. Bits [15:0] hold the active tick count A. In each period of P ticks, the output is at the active level for the first A ticks and at the inactive level for the rest. A = 0 gives an output that is never active. A = P gives an output that is always active.
- R4: When control bit 5 is 1, the active level is high. When it is 0, the active level is low. The inactive level is always the opposite of the active level.
- R5: The channel runs only when both the enable bit (4) and the gate bit (6) are 1. Otherwise the prescaler and the period counter are held at zero, and the output sits at the inactive level.
- R6: Prescaler codes 0x5, 0x6, 0x7, 0xD and 0xE produce no ticks. The channel does not run, and the output stays at the inactive level.
- R7: A write to the period word sets the ready flag (control bit 28). The written value takes effect at the next period boundary, and the flag clears on that same clock. While the channel is not running, the value takes effect on the clock after the write.
- R8: If a period write lands on the same clock as a boundary load, the write wins. The ready flag stays 1, and the newly written value is loaded at the following boundary.
- R9: After reset, both words read as zero, the ready flag is 0, and the output is high, which is the inactive level for an active level of 0.
- R10: When A is larger than P, the output is at the active level for the whole period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address of the word accessed |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 1 | Modulated output, registered |

## Verification
Two events can fall on the same clock: a bus write of the period word and a boundary load, which empties the shadow and clears the ready flag. While the channel is stopped, every clock is a boundary. Two period writes on consecutive clocks therefore put the second write exactly on the load of the first. The bench then reads the ready flag, which must still be 1 after that clock and 0 one clock later. It then enables the channel and measures the duty cycle, which must match the second value and not the first. A write into a long running period checks the other ordering. There the flag must stay set until the period wraps, and the duty cycle must then follow the new setting.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 4;
    localparam int CNT_W     = 16;
    localparam int DIV_W     = 17;
    localparam int CODE_W    = 4;
    localparam int READY_BIT = 28;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(4'h0);
    localparam logic [ADDR_W-1:0] PER_ADDR  = ADDR_W'(4'h4);

    // control word, bit 6 down to bit 0
    typedef struct packed {
        logic              gate;
        logic              pol;
        logic              en;
        logic [CODE_W-1:0] code;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // period word: upper half is length-1, lower half active ticks
    typedef struct packed {
        logic [CNT_W-1:0] len_m1;
        logic [CNT_W-1:0] act;
    } period_t;

    typedef struct packed {
        logic             valid;
        logic [DIV_W-1:0] lim;
    } presc_t;

    // terminal value of the divide counter for each code
    function automatic presc_t presc_decode(input logic [CODE_W-1:0] code);
        presc_t p;
        p.valid = 1'b1;
        case (code)
            4'h0:    p.lim = DIV_W'(120 - 1);
            4'h1:    p.lim = DIV_W'(180 - 1);
            4'h2:    p.lim = DIV_W'(240 - 1);
            4'h3:    p.lim = DIV_W'(360 - 1);
            4'h4:    p.lim = DIV_W'(480 - 1);
            4'h8:    p.lim = DIV_W'(12000 - 1);
            4'h9:    p.lim = DIV_W'(24000 - 1);
            4'hA:    p.lim = DIV_W'(36000 - 1);
            4'hB:    p.lim = DIV_W'(48000 - 1);
            4'hC:    p.lim = DIV_W'(72000 - 1);
            4'hF:    p.lim = '0;
            default: begin
                p.valid = 1'b0;
                p.lim   = '0;
            end
        endcase
        return p;
    endfunction

endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              load,
    output ctrl_t             ctrl,
    output period_t           shadow,
    output logic              pending
);

    logic wr_ctrl;
    logic wr_per;

    assign wr_ctrl = we && (addr == CTRL_ADDR);
    assign wr_per  = we && (addr == PER_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            shadow  <= '0;
            pending <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                ctrl <= ctrl_t'(wdata[CTRL_W-1:0]);
            end
            if (wr_per) begin
                shadow  <= period_t'(wdata);
                pending <= 1'b1;
            end else if (load) begin
                pending <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == CTRL_ADDR) begin
            rdata[CTRL_W-1:0] = ctrl;
            rdata[READY_BIT]  = pending;
        end else if (addr == PER_ADDR) begin
            rdata = shadow;
        end
    end

    // R7
    pend_set_chk: assert property (@(posedge clk) disable iff (rst)
        wr_per |=> pending);

    // R7
    pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pending) |-> $past(load));

endmodule

// File: rtl/pwm_presc.sv
module pwm_presc
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run_req,
    input  logic [CODE_W-1:0] code,
    output logic              run,
    output logic              tick
);

    presc_t           sel;
    logic [DIV_W-1:0] div_cnt;

    assign sel  = presc_decode(code);
    assign run  = run_req && sel.valid;
    assign tick = run && (div_cnt == sel.lim);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            div_cnt <= '0;
        end else if (tick) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // R2
    tick_space_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && $past(tick)) |-> (sel.lim == '0));

endmodule

// File: rtl/pwm_core.sv
module pwm_core
    import pwm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    run,
    input  logic    tick,
    input  logic    pol,
    input  period_t shadow,
    input  logic    pending,
    output logic    load,
    output logic    out
);

    period_t          cur;
    logic [CNT_W-1:0] cnt;
    logic             wrap;
    logic             boundary;
    logic             active;

    assign wrap     = tick && (cnt == cur.len_m1);
    assign boundary = !run || wrap;
    assign load     = boundary && pending;
    assign active   = cnt < cur.act;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur <= '0;
            cnt <= '0;
            out <= 1'b1;
        end else begin
            if (load) begin
                cur <= shadow;
            end
            if (!run) begin
                cnt <= '0;
            end else if (tick) begin
                cnt <= wrap ? '0 : cnt + 1'b1;
            end
            out <= run ? (active ? pol : !pol) : !pol;
        end
    end

    // R3
    cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= cur.len_m1);

    // R5
    idle_out_chk: assert property (@(posedge clk) disable iff (rst)
        !run |=> (out == !$past(pol)));

    // R10
    full_duty_chk: assert property (@(posedge clk) disable iff (rst)
        (run && ({1'b0, cur.act} > {1'b0, cur.len_m1})) |=> (out == $past(pol)));

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              pwm_out
);

    ctrl_t   ctrl;
    period_t shadow;
    logic    pending;
    logic    load;
    logic    run;
    logic    tick;

    pwm_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .addr    (bus_addr),
        .we      (bus_we),
        .wdata   (bus_wdata),
        .rdata   (bus_rdata),
        .load    (load),
        .ctrl    (ctrl),
        .shadow  (shadow),
        .pending (pending)
    );

    pwm_presc u_presc (
        .clk     (clk),
        .rst     (rst),
        .run_req (ctrl.en && ctrl.gate),
        .code    (ctrl.code),
        .run     (run),
        .tick    (tick)
    );

    pwm_core u_core (
        .clk     (clk),
        .rst     (rst),
        .run     (run),
        .tick    (tick),
        .pol     (ctrl.pol),
        .shadow  (shadow),
        .pending (pending),
        .load    (load),
        .out     (pwm_out)
    );

endmodule

// File: tb/sim_pwm_chan.sv
`timescale 1ns/1ps
module sim_pwm_chan;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pwm_out;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    pwm_chan u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    // {code, pol, len_m1, act, window, expected high clocks}
    localparam int NV = 11;
    localparam logic [87:0] VEC [NV] = '{
        {4'hF, 4'd1, 16'd3, 16'd2, 24'd16,    24'd8},     // R3 half duty
        {4'hF, 4'd0, 16'd9, 16'd3, 24'd30,    24'd21},    // R4 active low
        {4'hF, 4'd1, 16'd4, 16'd0, 24'd20,    24'd0},     // R3 zero duty
        {4'hF, 4'd1, 16'd4, 16'd5, 24'd20,    24'd20},    // R3 full duty
        {4'hF, 4'd1, 16'd2, 16'd9, 24'd15,    24'd15},    // R10 act > length
        {4'h0, 4'd1, 16'd1, 16'd1, 24'd480,   24'd240},   // R2 div 120
        {4'h4, 4'd1, 16'd2, 16'd1, 24'd1440,  24'd480},   // R2 div 480
        {4'h8, 4'd1, 16'd1, 16'd1, 24'd24000, 24'd12000}, // R2 div 12000
        {4'hA, 4'd0, 16'd1, 16'd1, 24'd72000, 24'd36000}, // R2 div 36000
        {4'h5, 4'd1, 16'd1, 16'd1, 24'd400,   24'd0},     // R6 dead code
        {4'hE, 4'd0, 16'd1, 16'd1, 24'd400,   24'd400}    // R6 dead code
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic measure(input int window, output int highs);
        highs = 0;
        for (int i = 0; i < window; i++) begin
            @(negedge clk);
            if (pwm_out) highs++;
        end
    endtask

    function automatic logic [31:0] ctrl_word(input logic [3:0] code, input logic pol,
                                              input logic en, input logic gate);
        return {25'b0, gate, pol, en, code};
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R9 watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int highs;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R9 reset state
        rd(4'h0, d); check("R9 ctrl", d, 32'h0);
        rd(4'h4, d); check("R9 period", d, 32'h0);
        check("R9 out", {31'b0, pwm_out}, 32'h1);

        // R1 readback and unused bits
        wr(4'h0, 32'hFFFF_FFFF);
        @(negedge clk);
        rd(4'h0, d); check("R1 ctrl readback", d, 32'h0000_007F);
        wr(4'h0, 32'h0);
        wr(4'h4, 32'h0012_3456);
        @(negedge clk);
        rd(4'h4, d); check("R1 period readback", d, 32'h0012_3456);
        rd(4'h8, d); check("R1 unmapped", d, 32'h0);

        // table of duty vectors
        for (int v = 0; v < NV; v++) begin
            logic [3:0]  code = VEC[v][87:84];
            logic        pol  = VEC[v][80];
            logic [15:0] lm1  = VEC[v][79:64];
            logic [15:0] act  = VEC[v][63:48];
            int          win  = int'(VEC[v][47:24]);
            int          exp  = int'(VEC[v][23:0]);
            wr(4'h0, ctrl_word(code, pol, 1'b0, 1'b0));
            wr(4'h4, {lm1, act});
            repeat (2) @(negedge clk);
            wr(4'h0, ctrl_word(code, pol, 1'b1, 1'b1));
            repeat (2) @(negedge clk);
            measure(win, highs);
            check($sformatf("R3 vector %0d duty", v), highs, exp);
        end

        // R5 gate off / enable off, active high so inactive is low
        wr(4'h0, 32'h0);
        wr(4'h4, {16'd3, 16'd2});
        wr(4'h0, ctrl_word(4'hF, 1'b1, 1'b1, 1'b0));
        @(negedge clk);
        measure(16, highs); check("R5 gate off", highs, 0);
        wr(4'h0, ctrl_word(4'hF, 1'b1, 1'b0, 1'b1));
        @(negedge clk);
        measure(16, highs); check("R5 enable off", highs, 0);

        // R7 write into a long running period
        wr(4'h0, 32'h0);
        wr(4'h4, {16'd99, 16'd50});
        repeat (2) @(negedge clk);
        wr(4'h0, ctrl_word(4'hF, 1'b1, 1'b1, 1'b1));
        repeat (5) @(negedge clk);
        wr(4'h4, {16'd9, 16'd5});
        rd(4'h0, d); check("R7 ready set", d[28], 1'b1);
        repeat (50) @(negedge clk);
        rd(4'h0, d); check("R7 ready held mid period", d[28], 1'b1);
        for (int i = 0; i < 120 && d[28]; i++) begin
            @(negedge clk);
            rd(4'h0, d);
        end
        check("R7 ready cleared", d[28], 1'b0);
        repeat (3) @(negedge clk);
        measure(30, highs); check("R7 new duty", highs, 15);

        // R8 write colliding with a load while stopped
        wr(4'h0, 32'h0);
        repeat (2) @(negedge clk);
        @(negedge clk);
        bus_addr = 4'h4; bus_we = 1'b1; bus_wdata = {16'd3, 16'd1};
        @(negedge clk);
        bus_wdata = {16'd3, 16'd3};
        @(negedge clk);
        bus_we = 1'b0;
        rd(4'h0, d); check("R8 ready kept", d[28], 1'b1);
        @(negedge clk);
        rd(4'h0, d); check("R8 ready cleared", d[28], 1'b0);
        wr(4'h0, ctrl_word(4'hF, 1'b1, 1'b1, 1'b1));
        repeat (2) @(negedge clk);
        measure(16, highs); check("R8 second value applied", highs, 12);

        // R7 stopped channel applies at once
        wr(4'h0, 32'h0);
        wr(4'h4, {16'd4, 16'd1});
        @(negedge clk);
        rd(4'h0, d); check("R7 stopped apply", d[28], 1'b0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule